// File: doc/BRIEF.md
# ARINC 429 receive filter and FIFO

This block sits between an ARINC 429 line deserializer and a host read port. The upstream logic hands it complete 32-bit words, each marked by a one-cycle valid strobe. The block screens each word against the current configuration. A word that passes is written into a 32-entry first-in first-out store. The host pops words one at a time with a read request. Three occupancy flags tell the host when the store is empty, when it holds at least 16 words, and when it is full.

The screening rules come from five control inputs:
- a receiver enable;
- an odd-parity check enable;
- an address decoder enable, with two match bits that bits 9 and 10 of the word are compared against.

A separate rate-select input drives a free-running bit-clock strobe for the upstream deserializer. The strobe runs at one tenth of the clock rate for the high-speed bus and at one eightieth for the low-speed bus.

Bus bit n (numbered 1 to 32) travels on `rx_word[n-1]`.

Top module: `arinc_rx_filter_fifo`

## Requirements
- R1: While `cfg_rx_en` is 0, strobed words are never stored: the occupancy and all flags stay as they were, apart from the effect of host pops.
- R2: With `cfg_par_en` = 1, a word is stored only if `rx_word[31:0]` contains an odd number of ones. With `cfg_par_en` = 0, words of either parity are stored.
- R3: With `cfg_dec_en` = 1, a word is stored only if `rx_word[8]` (bus bit 9) equals `cfg_match9` and `rx_word[9]` (bus bit 10) equals `cfg_match10`. With `cfg_dec_en` = 0, those two bits are not compared.
- R4: Stored words leave in arrival order. A `rd_req` sampled at a clock edge while the store is not empty places the oldest word on `rd_data` after that edge and removes it. `rd_data` is 0 after reset.
- R5: `fifo_half` is 1 exactly when 16 or more words are stored.
- R6: `fifo_empty` is 1 exactly when no word is stored. This holds after reset and after the last word has been read.
- R7: `fifo_full` is 1 exactly when 32 words are stored. An accepted word that arrives while the store is full and no pop happens in the same cycle is dropped, and the stored words are kept. If a pop happens in that same cycle, the word is stored.
- R8: A `rd_req` while the store is empty leaves `rd_data` and the occupancy unchanged. An accepted word arriving in that same cycle is still stored.
- R9: `bit_tick` pulses for one cycle every 10 clocks when `cfg_rate_sel` = 0, and every 80 clocks when `cfg_rate_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_word | input | 32 | Received word; bus bit n on index n-1 |
| rx_valid | input | 1 | One-cycle strobe marking a new word |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_par_en | input | 1 | Odd-parity check enable |
| cfg_dec_en | input | 1 | Bit 9/10 decoder enable |
| cfg_match9 | input | 1 | Required value of bus bit 9 |
| cfg_match10 | input | 1 | Required value of bus bit 10 |
| cfg_rate_sel | input | 1 | 0: bit rate clk/10, 1: bit rate clk/80 |
| rd_req | input | 1 | Host pop request |
| rd_data | output | 32 | Last word popped |
| fifo_empty | output | 1 | No word stored |
| fifo_half | output | 1 | 16 or more words stored |
| fifo_full | output | 1 | 32 words stored |
| bit_tick | output | 1 | Bit-clock strobe for the deserializer |

## Verification
The hardest case to reach from the ports is a full store that meets an accepted word. There are two variants: the word arrives with no pop in that cycle, or it arrives together with a pop. In each variant the pass/drop decision depends on the old occupancy and the pop at the same edge. A directed sequence fills the store to exactly 32 words, offers one marked word with no pop, and then offers a second marked word together with a pop. It then drains everything, which shows that only the second marker survived. Random phases alternate between pop-light and pop-heavy stretches, with parity, decoder and enable settings drawn at random. This drives the store across the 16-word mark and into overflow many times. A reference queue predicts every flag and every popped value.

// File: rtl/arinc_rx_pkg.sv
package arinc_rx_pkg;
   localparam int unsigned WORD_W = 32;
   // index of bus bit 9; bus bit 10 sits one above
   localparam int unsigned SD_LSB = 8;

   typedef struct packed {
      logic rx_en;
      logic par_en;
      logic dec_en;
      logic match9;
      logic match10;
   } rx_cfg_t;
endpackage

// File: rtl/arinc_rx_accept.sv
module arinc_rx_accept
   import arinc_rx_pkg::*;
#(
   parameter int unsigned W     = WORD_W,
   parameter int unsigned SD_LO = SD_LSB,
   parameter bit          ODD   = 1'b1
) (
   input  rx_cfg_t        cfg,
   input  logic [W-1:0]   word,
   input  logic           valid,
   output logic           accept
);
   logic par_good;
   logic dec_good;
   logic par_raw;

   generate
      if (ODD) begin : g_odd
         assign par_raw = ^word;
      end else begin : g_even
         assign par_raw = ~^word;
      end
   endgenerate

   always_comb begin
      par_good = cfg.par_en ? par_raw : 1'b1;
      dec_good = 1'b1;
      if (cfg.dec_en) begin
         dec_good = (word[SD_LO] == cfg.match9) && (word[SD_LO+1] == cfg.match10);
      end
      accept = valid && cfg.rx_en && par_good && dec_good;
   end
endmodule

// File: rtl/arinc_rx_fifo.sv
module arinc_rx_fifo #(
   parameter int unsigned W         = 32,
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned HALF_MARK = 16,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] occ,
   output logic          empty,
   output logic          half,
   output logic          full
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          pop_ok, push_ok;

   assign empty   = (occ == '0);
   assign full    = (occ == CW'(DEPTH));
   assign half    = (occ >= CW'(HALF_MARK));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
         rdata  <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr <= wr_nxt;
         end
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
            rdata  <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   occ <= occ + CW'(1);
            2'b01:   occ <= occ - CW'(1);
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/arinc_rx_rate.sv
module arinc_rx_rate #(
   parameter int unsigned HS_DIV = 10,
   parameter int unsigned LS_DIV = 80,
   localparam int unsigned MAXD  = (HS_DIV > LS_DIV) ? HS_DIV : LS_DIV,
   localparam int unsigned CW    = $clog2(MAXD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   output logic tick
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = sel ? CW'(LS_DIV - 1) : CW'(HS_DIV - 1);
   assign tick = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt >= lim) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/arinc_rx_filter_fifo.sv
module arinc_rx_filter_fifo
   import arinc_rx_pkg::*;
#(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned HALF_MARK = 16,
   parameter int unsigned HS_DIV    = 10,
   parameter int unsigned LS_DIV    = 80,
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_valid,
   input  logic              cfg_rx_en,
   input  logic              cfg_par_en,
   input  logic              cfg_dec_en,
   input  logic              cfg_match9,
   input  logic              cfg_match10,
   input  logic              cfg_rate_sel,
   input  logic              rd_req,
   output logic [WORD_W-1:0] rd_data,
   output logic              fifo_empty,
   output logic              fifo_half,
   output logic              fifo_full,
   output logic              bit_tick
);
   generate
      if (DEPTH < 2 || HALF_MARK < 1 || HALF_MARK > DEPTH) begin : g_bad_depth
         $error("arinc_rx_filter_fifo: DEPTH/HALF_MARK out of range");
      end
      if (HS_DIV < 2 || LS_DIV < 2) begin : g_bad_div
         $error("arinc_rx_filter_fifo: dividers must be at least 2");
      end
   endgenerate

   rx_cfg_t       cfg;
   logic          acc;
   logic [CW-1:0] occ;

   assign cfg = '{rx_en:   cfg_rx_en,
                  par_en:  cfg_par_en,
                  dec_en:  cfg_dec_en,
                  match9:  cfg_match9,
                  match10: cfg_match10};

   arinc_rx_accept #(.W(WORD_W), .SD_LO(SD_LSB), .ODD(1'b1)) u_accept (
      .cfg    (cfg),
      .word   (rx_word),
      .valid  (rx_valid),
      .accept (acc)
   );

   arinc_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (acc),
      .wdata (rx_word),
      .pop   (rd_req),
      .rdata (rd_data),
      .occ   (occ),
      .empty (fifo_empty),
      .half  (fifo_half),
      .full  (fifo_full)
   );

   arinc_rx_rate #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cfg_rate_sel),
      .tick  (bit_tick)
   );
endmodule

// File: rtl/arinc_rx_chk.sv
module arinc_rx_chk
   import arinc_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid,
   input logic              cfg_rx_en,
   input logic              cfg_par_en,
   input logic              cfg_dec_en,
   input logic              cfg_match9,
   input logic              cfg_match10,
   input logic              rd_req,
   input logic [WORD_W-1:0] rd_data,
   input logic              fifo_empty,
   input logic              fifo_half,
   input logic              fifo_full,
   input logic              bit_tick,
   input logic [CW-1:0]     occ
);
   logic real_pop;
   assign real_pop = rd_req && !fifo_empty;

   AST_RX_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rx_en && !real_pop) |=> $stable(occ)); // R1
   AST_PARITY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_par_en && !(^rx_word) && !real_pop) |=> $stable(occ)); // R2
   AST_DECODE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_dec_en && !real_pop &&
       ({rx_word[SD_LSB+1], rx_word[SD_LSB]} != {cfg_match10, cfg_match9})) |=> $stable(occ)); // R3
   AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> (fifo_half && !fifo_empty)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !rd_req) |=> (fifo_full && occ == CW'(DEPTH))); // R7
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && rd_req) |=> $stable(rd_data)); // R8
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick); // R9
endmodule

bind arinc_rx_filter_fifo arinc_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_word     (rx_word),
   .rx_valid    (rx_valid),
   .cfg_rx_en   (cfg_rx_en),
   .cfg_par_en  (cfg_par_en),
   .cfg_dec_en  (cfg_dec_en),
   .cfg_match9  (cfg_match9),
   .cfg_match10 (cfg_match10),
   .rd_req      (rd_req),
   .rd_data     (rd_data),
   .fifo_empty  (fifo_empty),
   .fifo_half   (fifo_half),
   .fifo_full   (fifo_full),
   .bit_tick    (bit_tick),
   .occ         (occ)
);

// File: tb/tb_arinc_rx_filter_fifo.sv
`timescale 1ns/1ps
module tb_arinc_rx_filter_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] rx_word = '0;
   logic        rx_valid = 1'b0;
   logic        cfg_rx_en = 1'b0, cfg_par_en = 1'b0, cfg_dec_en = 1'b0;
   logic        cfg_match9 = 1'b0, cfg_match10 = 1'b0, cfg_rate_sel = 1'b0;
   logic        rd_req = 1'b0;
   logic [31:0] rd_data;
   logic        fifo_empty, fifo_half, fifo_full, bit_tick;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [31:0] mq[$];
   logic [31:0] m_last = '0;
   bit          empty_pop = 0;

   always #2 clk = ~clk;

   arinc_rx_filter_fifo dut (
      .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
      .cfg_rx_en(cfg_rx_en), .cfg_par_en(cfg_par_en), .cfg_dec_en(cfg_dec_en),
      .cfg_match9(cfg_match9), .cfg_match10(cfg_match10), .cfg_rate_sel(cfg_rate_sel),
      .rd_req(rd_req), .rd_data(rd_data), .fifo_empty(fifo_empty),
      .fifo_half(fifo_half), .fifo_full(fifo_full), .bit_tick(bit_tick)
   );

   function automatic bit exp_accept(logic [31:0] w);
      bit ok = rx_valid && cfg_rx_en;
      if (cfg_par_en && ($countones(w) % 2 == 0)) ok = 0;
      if (cfg_dec_en && (w[8] != cfg_match9 || w[9] != cfg_match10)) ok = 0;
      return ok;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(fifo_empty == (mq.size() == 0), "R6 empty flag", 32'(fifo_empty), 32'(mq.size() == 0));
      check(fifo_half == (mq.size() >= 16), "R5 half flag", 32'(fifo_half), 32'(mq.size() >= 16));
      check(fifo_full == (mq.size() == 32), "R7 full flag", 32'(fifo_full), 32'(mq.size() == 32));
      check(rd_data == m_last, empty_pop ? "R8 rd_data held" : "R4 rd_data", rd_data, m_last);
   endtask

   // one clock: model update from the driven inputs, then compare after the edge
   task automatic step();
      bit acc, pop_ok, push_ok;
      @(posedge clk);
      acc     = exp_accept(rx_word);
      pop_ok  = rd_req && (mq.size() != 0);
      push_ok = acc && (mq.size() != 32 || pop_ok);
      empty_pop = rd_req && (mq.size() == 0);
      if (pop_ok) m_last = mq.pop_front();
      if (push_ok) mq.push_back(rx_word);
      #1;
      compare_all();
   endtask

   task automatic offer(logic [31:0] w, bit pop);
      rx_word = w; rx_valid = 1'b1; rd_req = pop;
      step();
      rx_valid = 1'b0; rd_req = 1'b0;
   endtask

   task automatic drain(output int n);
      n = 0;
      rd_req = 1'b1;
      while (!fifo_empty && n < 64) begin
         step();
         n++;
      end
      rd_req = 1'b0;
   endtask

   task automatic measure_rate(bit sel, int exp_gap);
      int gap;
      int guard;
      cfg_rate_sel = sel;
      guard = 0;
      step();
      while (!bit_tick && guard < 200) begin step(); guard++; end
      gap = 0;
      do begin step(); gap++; end while (!bit_tick && gap < 200);
      check(gap == exp_gap, sel ? "R9 low-speed tick gap" : "R9 high-speed tick gap",
            32'(gap), 32'(exp_gap));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      logic [31:0] w;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // reset state: R4 R5 R6 R7
      compare_all();
      rst_n = 1'b1;
      step();

      // R1: receiver disabled
      cfg_rx_en = 1'b0;
      offer(32'h0000_0001, 0);
      check(fifo_empty == 1'b1, "R1 disabled receiver stored a word", 32'(fifo_empty), 32'd1);
      cfg_rx_en = 1'b1;

      // R2: parity check on, even word rejected, odd word kept
      cfg_par_en = 1'b1;
      offer(32'h0000_0003, 0);
      check(fifo_empty == 1'b1, "R2 even parity accepted", 32'(fifo_empty), 32'd1);
      offer(32'h0000_0007, 0);
      drain(n);
      check(n == 1 && rd_data == 32'h0000_0007, "R2 odd parity word", rd_data, 32'h0000_0007);
      cfg_par_en = 1'b0;
      offer(32'h0000_0003, 0);
      drain(n);
      check(n == 1, "R2 parity disabled", 32'(n), 32'd1);

      // R3: decoder on with bit9=1 bit10=0; only [9:8]=01 passes
      cfg_dec_en = 1'b1; cfg_match9 = 1'b1; cfg_match10 = 1'b0;
      for (int k = 0; k < 4; k++) offer(32'hA000_0000 | (32'(k) << 8), 0);
      drain(n);
      check(n == 1 && rd_data == 32'hA000_0100, "R3 decoder match", rd_data, 32'hA000_0100);
      cfg_dec_en = 1'b0;
      for (int k = 0; k < 4; k++) offer(32'hB000_0000 | (32'(k) << 8), 0);
      drain(n);
      check(n == 4, "R3 decoder disabled", 32'(n), 32'd4);

      // R5 R7: fill across the 16 mark and to full
      for (int k = 0; k < 15; k++) offer(32'hC000_0000 + 32'(k), 0);
      check(fifo_half == 1'b0, "R5 half at 15", 32'(fifo_half), 32'd0);
      offer(32'hC000_000F, 0);
      check(fifo_half == 1'b1, "R5 half at 16", 32'(fifo_half), 32'd1);
      for (int k = 16; k < 32; k++) offer(32'hC000_0000 + 32'(k), 0);
      check(fifo_full == 1'b1, "R7 full at 32", 32'(fifo_full), 32'd1);
      offer(32'hDEAD_0001, 0);          // dropped
      check(fifo_full == 1'b1, "R7 full after overflow", 32'(fifo_full), 32'd1);
      offer(32'hBEEF_0002, 1);          // stored with pop
      check(rd_data == 32'hC000_0000, "R7 oldest kept", rd_data, 32'hC000_0000);
      drain(n);
      check(n == 32 && rd_data == 32'hBEEF_0002, "R7 drop vs push-with-pop", rd_data, 32'hBEEF_0002);
      check(fifo_empty == 1'b1, "R6 empty after drain", 32'(fifo_empty), 32'd1);

      // R8: pop on empty, alone and with a push
      rd_req = 1'b1; step(); rd_req = 1'b0;
      check(rd_data == 32'hBEEF_0002, "R8 empty pop holds data", rd_data, 32'hBEEF_0002);
      offer(32'h1234_5678, 1);
      check(fifo_empty == 1'b0 && rd_data == 32'hBEEF_0002, "R8 push during empty pop",
            32'(fifo_empty), 32'd0);
      drain(n);

      // random phases
      for (int c = 0; c < 4000; c++) begin
         if (c % 50 == 0) begin
            cfg_rx_en   = ($urandom % 8) != 0;
            cfg_par_en  = $urandom % 2;
            cfg_dec_en  = $urandom % 2;
            cfg_match9  = $urandom % 2;
            cfg_match10 = $urandom % 2;
         end
         w = $urandom;
         rx_word  = w;
         rx_valid = ($urandom % 10) < 7;
         rd_req   = ($urandom % 100) < (((c / 300) % 2 == 0) ? 12 : 75);
         step();
      end
      rx_valid = 1'b0; rd_req = 1'b0;

      measure_rate(1'b0, 10);
      measure_rate(1'b1, 80);
      measure_rate(1'b0, 10);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule